// File: doc/BRIEF.md
# Address Translation Sequencing Controller

This controller takes one memory access at a time, either an instruction fetch or a data load/store, together with the segment descriptor that covers its effective address. The descriptor's direct-store select bit picks one of two paths. When the bit is set, a data access is passed on to the direct-store path, and an instruction fetch is rejected with an instruction-side exception. When the bit is clear, the access is page-translated. The segment's VSID is joined with the page index of the effective address to form a 40-bit virtual page number, which together with the 12-bit page offset makes a 52-bit virtual address. That page number is then looked up in a small TLB; fetches and data accesses each have their own TLB.

On a TLB miss the controller asks an external table-search engine for the page through a request/acknowledge port. If the page is found, the controller installs the returned entry in the TLB for that side and repeats the lookup, which must now hit. If the page is not found, the controller reports a page fault. Once an entry is available, protection is evaluated from its two PP bits and the segment key. A disallowed access raises a protection exception. An allowed access delivers the physical address.

Each accepted access ends in exactly one single-cycle result: a physical address, a direct-store hand-off, or an exception. An exception carries a cause code, a side flag, and the faulting effective address.

Top module: `xlat_seq_ctrl`

## Requirements
- R1: `acc_ready` is high only while idle. An access is accepted when `acc_valid` and `acc_ready` are both high at a clock edge. Each accepted access produces exactly one single-cycle pulse on one of `res_valid`, `ds_valid` or `exc_valid`, and `acc_ready` is high again in the following cycle. When the access hits in the TLB or takes the direct-store path, the pulse comes in the second cycle after acceptance.
- R2: With `seg_t`=0, the page number is {`seg_vsid`, `acc_ea[27:12]`} (40 bits). A successful translation gives `res_pa` = {ppn, `acc_ea[11:0]`}.
- R3: A data access (`acc_is_fetch`=0) with `seg_t`=1 pulses `ds_valid`, with `ds_ea` equal to the access's EA. It makes no table-search request.
- R4: A fetch with `seg_t`=1 raises `exc_cause`=3 (direct-store fetch) with `exc_side`=1. It makes no table-search request and produces no result.
- R5: Fetches use the instruction TLB and loads/stores use the data TLB. An entry installed for one side does not hit for the other side. A hit makes no table-search request.
- R6: On a miss, `walk_req` rises with `walk_vpn` set to the page number. Both are held stable until `walk_ack` is sampled high, and exactly one request is made per miss.
- R7: When the search returns with `walk_found`=1, the returned ppn and pp are installed and the lookup is retried. The retry must hit, and the result is the same as a hit. A later access to the same page on the same side hits without a search.
- R8: When the search returns with `walk_found`=0, the controller raises `exc_cause`=1 (page fault). Nothing is installed, so the next access to that page searches again.
- R9: Protection rules, with key = `seg_key`. For key 0: pp=3 is read-only and all other pp values are read/write. For key 1: pp=0 is no-access, pp=1 and pp=3 are read-only, and pp=2 is read/write. A fetch counts as a read. A store to a read-only page, or any access to a no-access page, raises `exc_cause`=2 (protection).
- R10: During `exc_valid`, `exc_side` is 1 for fetches and 0 for loads/stores, and `exc_ea` holds the faulting EA. The cause codes are 0 none, 1 page fault, 2 protection, 3 direct-store fetch.
- R11: Each TLB holds `TLB_ENTRIES` entries and replaces them round-robin starting at entry 0. Installing the (N+1)th distinct page evicts the first one installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Controller idle, can accept |
| acc_is_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| acc_is_store | input | 1 | 1 = store (data only) |
| acc_ea | input | 32 | Effective address |
| seg_t | input | 1 | Segment direct-store select |
| seg_key | input | 1 | Segment protection key |
| seg_vsid | input | 24 | Segment virtual segment id |
| walk_req | output | 1 | Table-search request |
| walk_vpn | output | 40 | Page number to search |
| walk_ack | input | 1 | Search complete |
| walk_found | input | 1 | Search found the page |
| walk_ppn | input | 20 | Returned physical page number |
| walk_pp | input | 2 | Returned protection bits |
| res_valid | output | 1 | Physical address valid (one cycle) |
| res_pa | output | 32 | Physical address |
| ds_valid | output | 1 | Direct-store hand-off (one cycle) |
| ds_ea | output | 32 | EA handed to direct-store path |
| exc_valid | output | 1 | Exception (one cycle) |
| exc_cause | output | 2 | Exception cause code |
| exc_side | output | 1 | 1 = instruction side, 0 = data side |
| exc_ea | output | 32 | Faulting EA |

## Verification
The bench builds the controller with `TLB_ENTRIES`=2 and keeps the other parameters at their defaults. With only two entries, eviction after the third distinct page can be checked in a short sequence. The main sweep covers every combination of access kind, key, pp value, search outcome and direct-store bit, and each access is issued twice. The second issue confirms that a refill leaves a hitting entry with the correct latency, and that a page fault leaves no entry. The bench computes the page table from the page number, so each expected address and cause follows directly from the requirements.

// File: rtl/xlat_pkg.sv
// Shared types for the address translation sequencing controller.
// Assumes: cause encodings are visible at the block boundary and must not change.
package xlat_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_PGFAULT = 2'd1,
        CAUSE_PROT    = 2'd2,
        CAUSE_DSFETCH = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK,
        ST_REFILL,
        ST_RETRY,
        ST_DONE,
        ST_FAULT
    } state_e;

endpackage

// File: rtl/xlat_prot.sv
// Protection evaluator: decides whether an access is allowed from the
// segment key, the two page-protection bits and the access direction.
// Assumes: a fetch is presented as a read (is_store = 0).
module xlat_prot (
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       is_store,
    output logic       allow
);

    // Map key/pp to read-write, read-only or no-access and apply direction.
    always_comb begin
        case ({key, pp})
            3'b0_11:          allow = !is_store;
            3'b1_00:          allow = 1'b0;
            3'b1_01, 3'b1_11: allow = !is_store;
            default:          allow = 1'b1;
        endcase
    end

endmodule

// File: rtl/xlat_tlb.sv
// Small fully associative TLB with round-robin replacement.
// Assumes: a write is only issued for a page that currently misses, so at
// most one entry matches any lookup. ENTRIES must be 2 or more.
module xlat_tlb #(
    parameter int VPN_W   = 40,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic [1:0]       hit_pp,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_pp
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [1:0]         pp_q  [ENTRIES];
    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] match;

    // Per-entry tag comparators.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = vld_q[i] && (tag_q[i] == lk_vpn);
    end

    // Select the payload of the matching entry.
    always_comb begin
        hit     = |match;
        hit_ppn = '0;
        hit_pp  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_ppn = ppn_q[i];
                hit_pp  = pp_q[i];
            end
        end
    end

    // Valid bits and replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (wr_en) begin
            vld_q[rr_q] <= 1'b1;
            rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // Entry payload storage, written at the replacement pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[rr_q] <= wr_vpn;
            ppn_q[rr_q] <= wr_ppn;
            pp_q[rr_q]  <= wr_pp;
        end
    end

    // A refill must target a page that is absent (no duplicate entries).
    assert_no_dup_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_vpn == lk_vpn) |-> !hit);

endmodule

// File: rtl/xlat_seq_ctrl.sv
// Address translation sequencing controller. Accepts one access at a time,
// routes it to the direct-store or page path, looks up the per-side TLB,
// requests a table search on a miss, refills and retries, checks protection,
// and reports a physical address, a direct-store hand-off or an exception.
// Assumes: the table-search engine answers every request with one ack pulse.
module xlat_seq_ctrl
    import xlat_pkg::*;
#(
    parameter int EA_W        = 32,
    parameter int SEG_SEL_W   = 4,
    parameter int OFF_W       = 12,
    parameter int VSID_W      = 24,
    parameter int PPN_W       = 20,
    parameter int TLB_ENTRIES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_valid,
    output logic                              acc_ready,
    input  logic                              acc_is_fetch,
    input  logic                              acc_is_store,
    input  logic [EA_W-1:0]                   acc_ea,
    input  logic                              seg_t,
    input  logic                              seg_key,
    input  logic [VSID_W-1:0]                 seg_vsid,
    output logic                              walk_req,
    output logic [VSID_W+EA_W-SEG_SEL_W-OFF_W-1:0] walk_vpn,
    input  logic                              walk_ack,
    input  logic                              walk_found,
    input  logic [PPN_W-1:0]                  walk_ppn,
    input  logic [1:0]                        walk_pp,
    output logic                              res_valid,
    output logic [PPN_W+OFF_W-1:0]            res_pa,
    output logic                              ds_valid,
    output logic [EA_W-1:0]                   ds_ea,
    output logic                              exc_valid,
    output logic [1:0]                        exc_cause,
    output logic                              exc_side,
    output logic [EA_W-1:0]                   exc_ea
);

    localparam int PIDX_W = EA_W - SEG_SEL_W - OFF_W;
    localparam int VPN_W  = VSID_W + PIDX_W;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int SIDES  = 2; // index 0 data, index 1 instruction

    state_e              state_q;
    logic                fetch_q, store_q, t_q, key_q;
    logic [VSID_W-1:0]   vsid_q;
    logic [EA_W-1:0]     ea_q;
    logic [PPN_W-1:0]    fill_ppn_q;
    logic [1:0]          fill_pp_q;
    logic [PA_W-1:0]     pa_q;
    cause_e              cause_q;

    logic [VPN_W-1:0]    vpn;
    logic [SIDES-1:0]    side_hit;
    logic [PPN_W-1:0]    side_ppn [SIDES];
    logic [1:0]          side_pp  [SIDES];
    logic                sel_hit;
    logic [PPN_W-1:0]    sel_ppn;
    logic [1:0]          sel_pp;
    logic                allow;
    logic                in_xlate;

    // Page number from the latched segment id and EA page index.
    assign vpn = {vsid_q, ea_q[EA_W-SEG_SEL_W-1:OFF_W]};

    // One TLB per side; each is refilled only by accesses of its own side.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        logic wr_side;
        assign wr_side = (state_q == ST_REFILL) && (fetch_q == (s == 1));
        xlat_tlb #(
            .VPN_W   (VPN_W),
            .PPN_W   (PPN_W),
            .ENTRIES (TLB_ENTRIES)
        ) u_tlb (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_vpn  (vpn),
            .hit     (side_hit[s]),
            .hit_ppn (side_ppn[s]),
            .hit_pp  (side_pp[s]),
            .wr_en   (wr_side),
            .wr_vpn  (vpn),
            .wr_ppn  (fill_ppn_q),
            .wr_pp   (fill_pp_q)
        );
    end

    // Pick the TLB answer for the side of the current access.
    always_comb begin
        sel_hit = fetch_q ? side_hit[1] : side_hit[0];
        sel_ppn = fetch_q ? side_ppn[1] : side_ppn[0];
        sel_pp  = fetch_q ? side_pp[1]  : side_pp[0];
    end

    xlat_prot u_prot (
        .key      (key_q),
        .pp       (sel_pp),
        .is_store (store_q && !fetch_q),
        .allow    (allow)
    );

    assign in_xlate = (state_q == ST_LOOKUP) || (state_q == ST_RETRY);

    // Sequencing state machine and request/result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fetch_q    <= 1'b0;
            store_q    <= 1'b0;
            t_q        <= 1'b0;
            key_q      <= 1'b0;
            vsid_q     <= '0;
            ea_q       <= '0;
            fill_ppn_q <= '0;
            fill_pp_q  <= '0;
            pa_q       <= '0;
            cause_q    <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        fetch_q <= acc_is_fetch;
                        store_q <= acc_is_store;
                        t_q     <= seg_t;
                        key_q   <= seg_key;
                        vsid_q  <= seg_vsid;
                        ea_q    <= acc_ea;
                        cause_q <= CAUSE_NONE;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP, ST_RETRY: begin
                    if (t_q) begin
                        if (fetch_q) begin
                            cause_q <= CAUSE_DSFETCH;
                            state_q <= ST_FAULT;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end else if (sel_hit) begin
                        if (allow) begin
                            pa_q    <= {sel_ppn, ea_q[OFF_W-1:0]};
                            state_q <= ST_DONE;
                        end else begin
                            cause_q <= CAUSE_PROT;
                            state_q <= ST_FAULT;
                        end
                    end else begin
                        state_q <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (walk_ack) begin
                        if (walk_found) begin
                            fill_ppn_q <= walk_ppn;
                            fill_pp_q  <= walk_pp;
                            state_q    <= ST_REFILL;
                        end else begin
                            cause_q <= CAUSE_PGFAULT;
                            state_q <= ST_FAULT;
                        end
                    end
                end
                ST_REFILL: state_q <= ST_RETRY;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from state and latched request.
    always_comb begin
        acc_ready = (state_q == ST_IDLE);
        walk_req  = (state_q == ST_WALK);
        walk_vpn  = vpn;
        res_valid = (state_q == ST_DONE) && !t_q;
        res_pa    = pa_q;
        ds_valid  = (state_q == ST_DONE) && t_q;
        ds_ea     = ea_q;
        exc_valid = (state_q == ST_FAULT);
        exc_cause = exc_valid ? cause_q : CAUSE_NONE;
        exc_side  = fetch_q;
        exc_ea    = ea_q;
    end

    // At most one result kind per cycle.
    assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, ds_valid, exc_valid}));

    // After any result the controller is ready again.
    assert_ready_after_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || ds_valid || exc_valid) |=> acc_ready);

    // Direct-store hand-off is never taken by a fetch.
    assert_ds_data_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> !fetch_q);

    // Direct-store fetch exception is always instruction-side.
    assert_dsfetch_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == CAUSE_DSFETCH) |-> exc_side);

    // Search request and page number hold until acknowledged.
    assert_walk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));

    // The retried lookup after refill must hit.
    assert_retry_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETRY && !t_q) |-> sel_hit);

    // Translation states only occur with a request latched from idle.
    assert_lookup_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && acc_valid) |=> (in_xlate && !acc_ready));

endmodule

// File: tb/xlat_seq_ctrl_bench.sv
// Self-checking bench: sweeps access kind, key, pp, search outcome and
// direct-store bit; checks TLB side split and round-robin eviction.
module xlat_seq_ctrl_bench;

    localparam int NENT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic        acc_is_fetch = 1'b0;
    logic        acc_is_store = 1'b0;
    logic [31:0] acc_ea = '0;
    logic        seg_t = 1'b0;
    logic        seg_key = 1'b0;
    logic [23:0] seg_vsid = '0;
    logic        walk_req;
    logic [39:0] walk_vpn;
    logic        walk_ack = 1'b0;
    logic        walk_found = 1'b0;
    logic [19:0] walk_ppn = '0;
    logic [1:0]  walk_pp = '0;
    logic        res_valid;
    logic [31:0] res_pa;
    logic        ds_valid;
    logic [31:0] ds_ea;
    logic        exc_valid;
    logic [1:0]  exc_cause;
    logic        exc_side;
    logic [31:0] exc_ea;

    int checks = 0;
    int errors = 0;
    int walks  = 0;
    logic [39:0] last_vpn = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xlat_seq_ctrl #(.TLB_ENTRIES(NENT)) u_xlat_seq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_is_fetch(acc_is_fetch), .acc_is_store(acc_is_store), .acc_ea(acc_ea),
        .seg_t(seg_t), .seg_key(seg_key), .seg_vsid(seg_vsid),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack),
        .walk_found(walk_found), .walk_ppn(walk_ppn), .walk_pp(walk_pp),
        .res_valid(res_valid), .res_pa(res_pa),
        .ds_valid(ds_valid), .ds_ea(ds_ea),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_side(exc_side), .exc_ea(exc_ea)
    );

    // Page table model: found unless vpn[3:0]==F, ppn = vpn[19:0]^5A5A5, pp = vpn[5:4].
    function automatic bit pt_found(input logic [39:0] v);
        return v[3:0] != 4'hF;
    endfunction
    function automatic logic [19:0] pt_ppn(input logic [39:0] v);
        return v[19:0] ^ 20'h5A5A5;
    endfunction

    // Protection rule from R9.
    function automatic bit prot_ok(input bit key, input logic [1:0] pp, input bit st);
        if (!key) return (pp == 2'd3) ? !st : 1'b1;
        if (pp == 2'd0) return 1'b0;
        if (pp == 2'd2) return 1'b1;
        return !st;
    endfunction

    // Table-search responder: acks two cycles after a request is seen.
    initial begin
        int dly;
        dly = 0;
        forever begin
            @(negedge clk);
            if (walk_ack) begin
                walk_ack = 1'b0;
            end else if (walk_req) begin
                if (dly == 2) begin
                    walk_ack   = 1'b1;
                    walk_found = pt_found(walk_vpn);
                    walk_ppn   = pt_ppn(walk_vpn);
                    walk_pp    = walk_vpn[5:4];
                    last_vpn   = walk_vpn;
                    walks++;
                    dly = 0;
                end else begin
                    dly++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Result of one access.
    int          g_kind;   // 0 res, 1 ds, 2 exc, 3 none
    logic [31:0] g_val;    // pa, ds_ea or exc_ea
    logic [1:0]  g_cause;
    logic        g_side;
    int          g_lat;
    int          g_walks;
    bit          g_busy_ok;
    bit          g_ready_back;

    task automatic do_access(input bit fetch, input bit st, input bit t, input bit key,
                             input logic [23:0] vsid, input logic [31:0] ea);
        int w0;
        @(negedge clk);
        acc_is_fetch = fetch; acc_is_store = st; seg_t = t; seg_key = key;
        seg_vsid = vsid; acc_ea = ea; acc_valid = 1'b1;
        w0 = walks;
        @(negedge clk);
        acc_valid = 1'b0;
        g_lat = 1; g_kind = 3; g_busy_ok = 1'b1;
        for (int k = 0; k < 100; k++) begin
            if (res_valid || ds_valid || exc_valid) break;
            if (acc_ready) g_busy_ok = 1'b0;
            @(negedge clk);
            g_lat++;
        end
        if (res_valid)      begin g_kind = 0; g_val = res_pa; end
        else if (ds_valid)  begin g_kind = 1; g_val = ds_ea; end
        else if (exc_valid) begin g_kind = 2; g_val = exc_ea; end
        g_cause = exc_cause; g_side = exc_side;
        g_walks = walks - w0;
        @(negedge clk);
        g_ready_back = acc_ready;
    endtask

    // Issue an access and compare against the model.
    task automatic run_and_check(input bit fetch, input bit st, input bit t, input bit key,
                                 input logic [23:0] vsid, input logic [31:0] ea, input int exp_walks);
        logic [39:0] v;
        int          ek;
        logic [31:0] ev;
        logic [1:0]  ec;
        string       tg;
        v = {vsid, ea[27:12]};
        do_access(fetch, st, t, key, vsid, ea);
        ec = 2'd0;
        if (t) begin
            if (fetch) begin ek = 2; ec = 2'd3; ev = ea; tg = "R4"; end
            else       begin ek = 1; ev = ea; tg = "R3"; end
        end else if (!pt_found(v)) begin
            ek = 2; ec = 2'd1; ev = ea; tg = "R8";
        end else if (!prot_ok(key, v[5:4], st && !fetch)) begin
            ek = 2; ec = 2'd2; ev = ea; tg = "R9";
        end else begin
            ek = 0; ev = {pt_ppn(v), ea[11:0]}; tg = "R2";
        end
        chk(g_kind == ek, {tg, " kind"}, 64'(g_kind), 64'(ek));
        chk(g_val == ev, {tg, " value"}, 64'(g_val), 64'(ev));
        if (ek == 2) begin
            chk(g_cause == ec, "R10 cause", 64'(g_cause), 64'(ec));
            chk(g_side == fetch, "R10 side", 64'(g_side), 64'(fetch));
        end
        chk(g_walks == exp_walks, "R6 search count", 64'(g_walks), 64'(exp_walks));
        if (exp_walks > 0)
            chk(last_vpn == v, "R2 walk_vpn", 64'(last_vpn), 64'(v));
        else
            chk(g_lat == 2, "R1 hit latency", 64'(g_lat), 64'd2);
        chk(g_busy_ok && g_ready_back, "R1 ready handshake",
            64'({g_busy_ok, g_ready_back}), 64'd3);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] ea;
        logic [23:0] vs;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(acc_ready && !walk_req && !res_valid && !ds_valid && !exc_valid, "R1 reset state",
            64'({acc_ready, walk_req, res_valid, ds_valid, exc_valid}), 64'b10000);
        rst_n = 1'b1;

        // Main sweep; each access issued twice (R7 retry/hit, R8 no install).
        n = 0;
        for (int op = 0; op < 3; op++)
            for (int key = 0; key < 2; key++)
                for (int pp = 0; pp < 4; pp++)
                    for (int fnd = 0; fnd < 2; fnd++)
                        for (int t = 0; t < 2; t++) begin
                            logic [9:0] nn;
                            n++;
                            nn = n[9:0];
                            vs = 24'h100000 + 24'(n * 3);
                            ea = {4'h3, nn, 2'(pp), (fnd != 0) ? 4'h1 : 4'hF, 12'(n * 37)};
                            run_and_check(op == 2, op == 1, t != 0, key != 0, vs, ea,
                                          (t == 0) ? 1 : 0);
                            run_and_check(op == 2, op == 1, t != 0, key != 0, vs, ea,
                                          (t == 0 && fnd == 0) ? 1 : 0);
                        end

        // R5: side separation of the two TLBs.
        vs = 24'h0ABCDE; ea = 32'h0123_4456;
        run_and_check(1'b0, 1'b0, 1'b0, 1'b0, vs, ea, 1); // data fill
        run_and_check(1'b1, 1'b0, 1'b0, 1'b0, vs, ea, 1); // R5 fetch must search
        run_and_check(1'b0, 1'b0, 1'b0, 1'b0, vs, ea, 0); // R5 data still hits
        run_and_check(1'b1, 1'b0, 1'b0, 1'b0, vs, ea, 0); // R5 instr hits

        // R11: round-robin eviction in the data TLB (2 entries).
        vs = 24'h777000;
        run_and_check(1'b0, 1'b0, 1'b0, 1'b0, vs, 32'h0001_1000, 1); // A
        run_and_check(1'b0, 1'b0, 1'b0, 1'b0, vs, 32'h0002_2000, 1); // B
        run_and_check(1'b0, 1'b0, 1'b0, 1'b0, vs, 32'h0003_2000, 1); // C evicts A
        run_and_check(1'b0, 1'b0, 1'b0, 1'b0, vs, 32'h0002_2000, 0); // R11 B kept
        run_and_check(1'b0, 1'b0, 1'b0, 1'b0, vs, 32'h0001_1000, 1); // R11 A evicted

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule